// File: doc/BRIEF.md
# Output Board Bus Register Interface

This block is the slave-side register interface of a 32-channel analog output board on a 16-bit parallel bus. It claims accesses whose upper address bits and access-mode bit match strap inputs. It decodes a 64-word window that holds an identification word, a combined control/status word, the converter result word, a reserved span and one data word per output channel. Each accepted access is answered with a data acknowledge. The acknowledge is held until the host drops its byte strobes.

The control/status location has two meanings. A write sets static control bits, which leave the block on `ctrlStatic`. Three bit positions instead fire one-cycle command pulses towards the conversion controller and are never stored. A read returns the stored controls, with those three positions replaced by live flags from the conversion controller. Channel words keep a 12-bit code. A separate read port gives the refresh sequencer combinational access to any stored code.

Top module: `aobus_regs`

## Requirements
- R1: An access is claimed only when `busAddr[15:7]` equals `strapBase` and `amBit` equals `strapAm`. An unclaimed access gets no acknowledge and changes no stored state.
- R2: `ack` rises at the first clock edge on which a claimed access shows any byte strobe. It stays high while any strobe is held and falls at the first edge after both strobes are low. Each strobe assertion performs exactly one access, and read data is valid while `ack` is high.
- R3: Byte offset 0x00 reads 0x1700, the value 0x17 sitting in the even byte (bits 15:8). Writes to it are acknowledged and discarded.
- R4: After reset the control word is zero. With all flags low, offset 0x02 reads 0x0000.
- R5: A write to offset 0x02 stores every bit except 15, 13 and 6. `dataStrobe[1]` enables bits 15:8 and `dataStrobe[0]` enables bits 7:0. Bits without an enabled strobe keep their value.
- R6: A write of 1 to bit 15, 13 or 6 of offset 0x02, with its byte strobe enabled, drives `pulseShortSettle`, `pulseStartConv` or `pulseStartSettle` high for exactly one cycle, in the cycle in which `ack` first reads high.
- R7: A read of offset 0x02 returns the stored control bits, with bit 15 = `flagNewData`, bit 13 = `flagConvBusy` and bit 6 = `flagSettleBusy`.
- R8: Offset 0x04 reads `adcData`. Writes to it are acknowledged and discarded.
- R9: Offsets 0x06 to 0x3E read as zero and ignore writes.
- R10: Offset 0x40 + 2n holds the 12-bit code of channel n. When control bit 12 is 0 (offset binary), bits 15:12 read as zero. When it is 1 (two's complement), bits 15:12 read as copies of bit 11.
- R11: Channel writes honour the byte strobes: `dataStrobe[1]` updates code bits 11:8 and `dataStrobe[0]` updates bits 7:0.
- R12: `refCode` always shows the stored code of the channel selected by `refIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 15 | Word address bits 15:1 |
| amBit | input | 1 | Access-mode (supervisory/non-privileged) bit of the cycle |
| strapBase | input | 9 | Strapped value for address bits 15:7 |
| strapAm | input | 1 | Strapped access-mode value |
| dataStrobe | input | 2 | Byte strobes, [1] bits 15:8, [0] bits 7:0, active high |
| writeEn | input | 1 | 1 = write, 0 = read |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid while ack is high |
| ack | output | 1 | Data acknowledge |
| flagNewData | input | 1 | Converter result ready flag |
| flagConvBusy | input | 1 | Conversion in progress flag |
| flagSettleBusy | input | 1 | Settling interval in progress flag |
| adcData | input | 16 | Converter result word |
| ctrlStatic | output | 16 | Stored control bits (15, 13, 6 always zero) |
| pulseShortSettle | output | 1 | One-cycle pulse from control bit 15 |
| pulseStartConv | output | 1 | One-cycle pulse from control bit 13 |
| pulseStartSettle | output | 1 | One-cycle pulse from control bit 6 |
| refIdx | input | 5 | Channel selected by the refresh sequencer |
| refCode | output | 12 | Stored code of the selected channel |

## Verification
The assertions assume that the host keeps address, direction and write data steady from the first strobe edge until it drops the strobes. They also assume that the strobes stay low during reset. The bench drives every input on the falling edge and changes the address only while the strobes are low. Between accesses it always leaves one cycle with both strobes low, so the acknowledge can complete its release before the next cycle begins.

// File: rtl/aobus_pkg.sv
package aobus_pkg;
  localparam int NUM_CH = 32;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int STB_SHORT = 15;
  localparam int STB_CONV = 13;
  localparam int STB_SETTLE = 6;
  localparam int TWOS_BIT = 12;

  typedef enum logic [2:0] {
    RG_ID, RG_CSR, RG_ADC, RG_RSVD, RG_CHAN
  } region_e;

  // per-access strobes from decode control to the datapath
  typedef struct packed {
    logic accept;
    logic isWrite;
    region_e region;
    logic [CH_W-1:0] chan;
    logic [1:0] byteEn;
  } busCmd_t;
endpackage

// File: rtl/aobus_ctrl.sv
module aobus_ctrl
  import aobus_pkg::*;
#(
  parameter int BASE_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:1]       busAddr,
  input  logic              amBit,
  input  logic [BASE_W-1:0] strapBase,
  input  logic              strapAm,
  input  logic [1:0]        dataStrobe,
  input  logic              writeEn,
  output busCmd_t           cmd,
  output logic              ack
);
  localparam int WORD_W = 15 - BASE_W;

  logic [WORD_W-1:0] wordIdx;
  logic sel, active, ackQ;
  region_e region;

  assign wordIdx = busAddr[WORD_W:1];
  assign sel = (busAddr[15:WORD_W+1] == strapBase) && (amBit == strapAm);
  assign active = |dataStrobe;

  always_comb begin
    if (wordIdx[WORD_W-1]) region = RG_CHAN;
    else begin
      case (wordIdx[WORD_W-2:0])
        '0:      region = RG_ID;
        1:       region = RG_CSR;
        2:       region = RG_ADC;
        default: region = RG_RSVD;
      endcase
    end
  end

  assign cmd.accept  = sel && active && !ackQ;
  assign cmd.isWrite = writeEn;
  assign cmd.region  = region;
  assign cmd.chan    = wordIdx[CH_W-1:0];
  assign cmd.byteEn  = dataStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else if (ackQ) ackQ <= active;
    else ackQ <= cmd.accept;
  end

  assign ack = ackQ;

  // R2
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackQ && !active) |=> !ackQ);
  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackQ && active) |=> ackQ);
  // R1
  ack_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackQ) |-> $past(sel && active));
endmodule

// File: rtl/aobus_datapath.sv
module aobus_datapath
  import aobus_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter logic [7:0] ID_VAL = 8'h17
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  input  logic [15:0]       wrData,
  input  logic              flagNewData,
  input  logic              flagConvBusy,
  input  logic              flagSettleBusy,
  input  logic [15:0]       adcData,
  input  logic [CH_W-1:0]   refIdx,
  output logic [15:0]       rdData,
  output logic [15:0]       ctrlStatic,
  output logic [2:0]        pulses,
  output logic [CODE_W-1:0] refCode
);
  localparam logic [15:0] STB_MASK =
    16'(1 << STB_SHORT) | 16'(1 << STB_CONV) | 16'(1 << STB_SETTLE);

  logic [15:0] ctrlQ, rdQ, readMux, byteMask, statusWord;
  logic [2:0] pulseQ;
  logic [CODE_W-1:0] chanFlat [NUM_CH];
  logic [CODE_W-1:0] selCode;
  logic csrWr, chanWr;

  assign byteMask = {{8{cmd.byteEn[1]}}, {8{cmd.byteEn[0]}}};
  assign csrWr  = cmd.accept && cmd.isWrite && (cmd.region == RG_CSR);
  assign chanWr = cmd.accept && cmd.isWrite && (cmd.region == RG_CHAN);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [CODE_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) word <= '0;
      else if (chanWr && cmd.chan == CH_W'(g))
        word <= (word & ~byteMask[CODE_W-1:0]) | (wrData[CODE_W-1:0] & byteMask[CODE_W-1:0]);
    end
    assign chanFlat[g] = word;
  end

  assign selCode = chanFlat[cmd.chan];
  assign refCode = chanFlat[refIdx];

  always_comb begin
    statusWord = ctrlQ;
    statusWord[STB_SHORT]  = flagNewData;
    statusWord[STB_CONV]   = flagConvBusy;
    statusWord[STB_SETTLE] = flagSettleBusy;
  end

  always_comb begin
    case (cmd.region)
      RG_ID:   readMux = {ID_VAL, 8'h00};
      RG_CSR:  readMux = statusWord;
      RG_ADC:  readMux = adcData;
      RG_CHAN: readMux = ctrlQ[TWOS_BIT] ? {{(16-CODE_W){selCode[CODE_W-1]}}, selCode}
                                         : {{(16-CODE_W){1'b0}}, selCode};
      default: readMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      pulseQ <= '0;
      rdQ    <= '0;
    end else begin
      pulseQ <= '0;
      if (cmd.accept) begin
        rdQ <= cmd.isWrite ? 16'h0000 : readMux;
        if (csrWr) begin
          ctrlQ  <= (ctrlQ & ~byteMask) | (wrData & byteMask & ~STB_MASK);
          pulseQ <= {wrData[STB_SHORT] & cmd.byteEn[1],
                     wrData[STB_CONV] & cmd.byteEn[1],
                     wrData[STB_SETTLE] & cmd.byteEn[0]};
        end
      end
    end
  end

  assign rdData = rdQ;
  assign ctrlStatic = ctrlQ;
  assign pulses = pulseQ;

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|pulseQ) |=> !(|pulseQ));
  // R6
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|pulseQ) |-> $past(cmd.accept && cmd.isWrite && cmd.region == RG_CSR));
  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cmd.accept && cmd.isWrite) |-> $stable(ctrlQ));
  // R9
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.accept && !cmd.isWrite && cmd.region == RG_RSVD) |-> (rdQ == 16'h0000));
endmodule

// File: rtl/aobus_regs.sv
module aobus_regs
  import aobus_pkg::*;
#(
  parameter int BASE_W = 9,
  parameter int CODE_W = 12,
  parameter logic [7:0] ID_VAL = 8'h17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:1]       busAddr,
  input  logic              amBit,
  input  logic [BASE_W-1:0] strapBase,
  input  logic              strapAm,
  input  logic [1:0]        dataStrobe,
  input  logic              writeEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              ack,
  input  logic              flagNewData,
  input  logic              flagConvBusy,
  input  logic              flagSettleBusy,
  input  logic [15:0]       adcData,
  output logic [15:0]       ctrlStatic,
  output logic              pulseShortSettle,
  output logic              pulseStartConv,
  output logic              pulseStartSettle,
  input  logic [CH_W-1:0]   refIdx,
  output logic [CODE_W-1:0] refCode
);
  busCmd_t cmd;
  logic [2:0] pulses;

  aobus_ctrl #(.BASE_W(BASE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .amBit(amBit),
    .strapBase(strapBase), .strapAm(strapAm), .dataStrobe(dataStrobe),
    .writeEn(writeEn), .cmd(cmd), .ack(ack)
  );

  aobus_datapath #(.CODE_W(CODE_W), .ID_VAL(ID_VAL)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .flagNewData(flagNewData), .flagConvBusy(flagConvBusy),
    .flagSettleBusy(flagSettleBusy), .adcData(adcData), .refIdx(refIdx),
    .rdData(rdData), .ctrlStatic(ctrlStatic), .pulses(pulses), .refCode(refCode)
  );

  assign {pulseShortSettle, pulseStartConv, pulseStartSettle} = pulses;
endmodule

// File: tb/aobus_regs_tb.sv
module aobus_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] BASE = 9'h11D;
  localparam logic [15:0] BASE_ADDR = {BASE, 7'b0};

  typedef struct packed {
    logic w;
    logic [7:0] off;
    logic [1:0] ds;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 2'b11, 16'h0000, 16'h1700, 4'd3},   // R3
    '{1'b1, 8'h00, 2'b11, 16'hFFFF, 16'h0000, 4'd3},
    '{1'b0, 8'h00, 2'b11, 16'h0000, 16'h1700, 4'd3},
    '{1'b0, 8'h02, 2'b11, 16'h0000, 16'h0000, 4'd4},   // R4
    '{1'b1, 8'h02, 2'b01, 16'hFFFF, 16'h0000, 4'd5},   // R5
    '{1'b0, 8'h02, 2'b11, 16'h0000, 16'h00BF, 4'd5},
    '{1'b1, 8'h02, 2'b11, 16'h4800, 16'h0000, 4'd5},
    '{1'b0, 8'h02, 2'b11, 16'h0000, 16'h4800, 4'd5},
    '{1'b1, 8'h40, 2'b11, 16'h0ABC, 16'h0000, 4'd10},  // R10
    '{1'b0, 8'h40, 2'b11, 16'h0000, 16'h0ABC, 4'd10},
    '{1'b1, 8'h7E, 2'b11, 16'hF123, 16'h0000, 4'd10},
    '{1'b0, 8'h7E, 2'b11, 16'h0000, 16'h0123, 4'd10},
    '{1'b1, 8'h4A, 2'b10, 16'h0F00, 16'h0000, 4'd11},  // R11
    '{1'b0, 8'h4A, 2'b11, 16'h0000, 16'h0F00, 4'd11},
    '{1'b1, 8'h4A, 2'b01, 16'h1234, 16'h0000, 4'd11},
    '{1'b0, 8'h4A, 2'b11, 16'h0000, 16'h0F34, 4'd11},
    '{1'b1, 8'h06, 2'b11, 16'hFFFF, 16'h0000, 4'd9},   // R9
    '{1'b0, 8'h06, 2'b11, 16'h0000, 16'h0000, 4'd9},
    '{1'b0, 8'h3E, 2'b11, 16'h0000, 16'h0000, 4'd9},
    '{1'b0, 8'h04, 2'b11, 16'h0000, 16'h0C5A, 4'd8},   // R8
    '{1'b1, 8'h04, 2'b11, 16'hFFFF, 16'h0000, 4'd8},
    '{1'b0, 8'h04, 2'b11, 16'h0000, 16'h0C5A, 4'd8},
    '{1'b1, 8'h02, 2'b11, 16'h1000, 16'h0000, 4'd10},  // R10 two's complement
    '{1'b0, 8'h7E, 2'b11, 16'h0000, 16'h0123, 4'd10},
    '{1'b0, 8'h40, 2'b11, 16'h0000, 16'hFABC, 4'd10}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:1] busAddr = '0;
  logic amBit = 1'b0;
  logic [8:0] strapBase = BASE;
  logic strapAm = 1'b0;
  logic [1:0] dataStrobe = 2'b00;
  logic writeEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic ack;
  logic flagNewData = 1'b0, flagConvBusy = 1'b0, flagSettleBusy = 1'b0;
  logic [15:0] adcData = 16'h0C5A;
  logic [15:0] ctrlStatic;
  logic pulseShortSettle, pulseStartConv, pulseStartSettle;
  logic [4:0] refIdx = '0;
  logic [11:0] refCode;

  int checkCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aobus_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .amBit(amBit),
    .strapBase(strapBase), .strapAm(strapAm), .dataStrobe(dataStrobe),
    .writeEn(writeEn), .wrData(wrData), .rdData(rdData), .ack(ack),
    .flagNewData(flagNewData), .flagConvBusy(flagConvBusy),
    .flagSettleBusy(flagSettleBusy), .adcData(adcData), .ctrlStatic(ctrlStatic),
    .pulseShortSettle(pulseShortSettle), .pulseStartConv(pulseStartConv),
    .pulseStartSettle(pulseStartSettle), .refIdx(refIdx), .refCode(refCode)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic am,
                        input logic [1:0] ds, input logic [15:0] wd,
                        output logic [15:0] rd, output logic acked,
                        output logic [2:0] pc);
    @(negedge clk);
    busAddr = a[15:1]; amBit = am; writeEn = w; wrData = wd; dataStrobe = ds;
    @(negedge clk);
    rd = rdData; acked = ack;
    pc = {pulseShortSettle, pulseStartConv, pulseStartSettle};
    dataStrobe = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCnt++; checkCnt++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic acked;
    logic [2:0] pc;
    int pulseCycles;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk("R4 ack after reset", {15'd0, ack}, 16'h0000);
    chk("R4 ctrlStatic after reset", ctrlStatic, 16'h0000);
    chk("R6 pulses after reset", {13'd0, pulseShortSettle, pulseStartConv, pulseStartSettle}, 16'h0000);
    chk("R12 refCode after reset", {4'd0, refCode}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].w, BASE_ADDR | 16'(VECS[i].off), strapAm, VECS[i].ds, VECS[i].wd, rd, acked, pc);
      chk($sformatf("R%0d ack row %0d", VECS[i].req, i), {15'd0, acked}, 16'h0001);
      if (!VECS[i].w)
        chk($sformatf("R%0d read row %0d", VECS[i].req, i), rd, VECS[i].exp);
    end

    // R12 refresh port
    refIdx = 5'd5; #1;
    chk("R12 refCode ch5", {4'd0, refCode}, 16'h0F34);
    refIdx = 5'd31; #1;
    chk("R12 refCode ch31", {4'd0, refCode}, 16'h0123);

    // R1 wrong base: no ack, no write
    access(1'b1, 16'h9E80 | 16'h0042, strapAm, 2'b11, 16'h0555, rd, acked, pc);
    chk("R1 wrong base ack", {15'd0, acked}, 16'h0000);
    access(1'b1, BASE_ADDR | 16'h0042, ~strapAm, 2'b11, 16'h0666, rd, acked, pc);
    chk("R1 wrong mode ack", {15'd0, acked}, 16'h0000);
    access(1'b0, BASE_ADDR | 16'h0042, strapAm, 2'b11, 16'h0000, rd, acked, pc);
    chk("R1 channel 1 untouched", rd, 16'h0000);

    // R7 status flags replace strobe positions
    flagNewData = 1'b1; flagSettleBusy = 1'b1;
    access(1'b0, BASE_ADDR | 16'h0002, strapAm, 2'b11, 16'h0000, rd, acked, pc);
    chk("R7 status read", rd, 16'h9040);
    flagNewData = 1'b0; flagSettleBusy = 1'b0; flagConvBusy = 1'b1;
    access(1'b0, BASE_ADDR | 16'h0002, strapAm, 2'b11, 16'h0000, rd, acked, pc);
    chk("R7 busy flag read", rd, 16'h3000);
    flagConvBusy = 1'b0;

    // R6 all strobes
    access(1'b1, BASE_ADDR | 16'h0002, strapAm, 2'b11, 16'hA040, rd, acked, pc);
    chk("R6 pulses on write", {13'd0, pc}, 16'h0007);
    chk("R6 strobes not stored", ctrlStatic, 16'h0000);
    chk("R6 pulses cleared", {13'd0, pulseShortSettle, pulseStartConv, pulseStartSettle}, 16'h0000);
    // R6 low byte only
    access(1'b1, BASE_ADDR | 16'h0002, strapAm, 2'b01, 16'hA040, rd, acked, pc);
    chk("R6 byte strobe pulse", {13'd0, pc}, 16'h0001);

    // R2 held strobes: ack held, one access, one pulse
    @(negedge clk);
    busAddr = (BASE_ADDR | 16'h0002) >> 1; amBit = strapAm; writeEn = 1'b1;
    wrData = 16'h2000; dataStrobe = 2'b11;
    pulseCycles = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (pulseStartConv) pulseCycles++;
      chk("R2 ack held", {15'd0, ack}, 16'h0001);
    end
    chk("R2 single pulse while held", 16'(pulseCycles), 16'h0001);
    dataStrobe = 2'b00;
    @(negedge clk);
    chk("R2 ack released", {15'd0, ack}, 16'h0000);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule